// File: doc/BRIEF.md
# Row-Restarting Five-Sample Running-Sum Filter

This block turns a stream of signed samples into a stream of causal window sums. Each valid sample, together with the four valid samples before it in the same row, produces one sum. The sum is kept as a running total. Each update adds the arriving sample and removes the one that falls out of the five-sample window, so the block needs one adder and one subtractor no matter how wide the window is.

Samples are grouped into rows of `ROW_LEN` valid samples. The block keeps its own column count, which moves forward only on valid input. After the last column of a row it clears the running total and the stored samples, so no sum ever mixes two rows. During the first four samples of each row the output register carries the partial total, but the valid flag stays low. A typical use is the horizontal half of a separable box filter on a product stream.

Top module: `rsum_row_filter`

## Requirements
- R1: Synchronous active-high reset forces `out_valid` to 0, `out_sum` to 0 and the column count to 0 at the next clock edge. This holds even when `in_valid` is high in the same cycle.
- R2: Outputs appear one clock after the sample that causes them. `out_valid` is 1 in the cycle after a valid sample whose zero-based column index within its row is 4 or more.
- R3: On each valid sample, `out_sum` becomes the sum of that sample and the previous four valid samples of the same row. Each sample is sign-extended from `DIN_W` bits, and the sum wraps modulo 2^`SUM_W`. For example, with 32-bit width, five copies of 0x7FFFFFFF give 0x7FFFFFFB.
- R4: For the first four valid samples of each row (columns 0 to 3), `out_valid` stays 0. `out_sum` shows the partial sum of the row's samples so far.
- R5: A cycle with `in_valid` low does not move the column count. In the next cycle `out_valid` is 0 and `out_sum` keeps its previous value.
- R6: After a valid sample at column `ROW_LEN`-1, that sample's sum is still produced in full. The next valid sample is column 0 of a new row, and its sum contains no earlier sample.
- R7: A row made only of the value 1 yields 1, 2, 3, 4 during fill, then 5 on every valid output.
- R8: Negative samples (most significant input bit set) subtract from the sum.
- R9: A reset in the middle of a row discards the stored samples and the column count. Five more valid samples are then needed before `out_valid` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks `in_data` as a sample |
| in_data | input | DIN_W | Signed sample |
| out_valid | output | 1 | Marks `out_sum` as a full five-sample sum |
| out_sum | output | SUM_W | Registered signed window sum |

## Verification
The delicate cycle is the last sample of a row. In that one edge the block must register the full sum, which still includes the window's oldest stored sample, and also wipe the total and the stored samples for the next row. The stimulus table ends one row with rising values and starts the next row with negative values. The bench judges this by checking the final sum of the first row and then the partial sums of the new row, which must contain none of the old samples. A second collision, reset asserted together with a valid sample, is driven directly and must leave the outputs cleared.

// File: rtl/rsum_pkg.sv
package rsum_pkg;
  localparam int unsigned TAPS = 5;

  function automatic int unsigned col_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rsum_col_tracker.sv
module rsum_col_tracker #(
  parameter int unsigned ROW_LEN = 128,
  parameter int unsigned COL_W   = rsum_pkg::col_width(ROW_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [COL_W-1:0] col,
  output logic             row_last,
  output logic             fill_done
);
  localparam logic [31:0] LAST_IDX = 32'(ROW_LEN - 1);
  localparam logic [31:0] FILL_IDX = 32'(rsum_pkg::TAPS - 1);

  logic [COL_W-1:0] col_q;

  assign row_last  = (32'(col_q) == LAST_IDX);
  assign fill_done = (32'(col_q) >= FILL_IDX);
  assign col       = col_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q <= '0;
    end else if (adv) begin
      if (row_last) col_q <= '0;
      else          col_q <= col_q + 1'b1;
    end
  end
endmodule

// File: rtl/rsum_window.sv
module rsum_window #(
  parameter int unsigned SUM_W = 32,
  parameter int unsigned TAPS  = rsum_pkg::TAPS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift,
  input  logic             clear,
  input  logic [SUM_W-1:0] din,
  output logic [SUM_W-1:0] leaving
);
  logic [SUM_W-1:0] slot [TAPS];

  for (genvar i = 0; i < TAPS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        slot[i] <= '0;
      end else if (shift) begin
        if (clear)       slot[i] <= '0;
        else if (i == 0) slot[i] <= din;
        else             slot[i] <= slot[(i > 0) ? i - 1 : 0];
      end
    end
  end

  assign leaving = slot[TAPS-1];
endmodule

// File: rtl/rsum_accum.sv
module rsum_accum #(
  parameter int unsigned SUM_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             clear,
  input  logic             fill_done,
  input  logic [SUM_W-1:0] din,
  input  logic [SUM_W-1:0] leaving,
  output logic             out_valid,
  output logic [SUM_W-1:0] out_sum
);
  logic [SUM_W-1:0] acc_q;
  logic [SUM_W-1:0] acc_next;

  assign acc_next = acc_q + din - leaving;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      out_sum   <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= step && fill_done;
      if (step) begin
        out_sum <= acc_next;
        acc_q   <= clear ? '0 : acc_next;
      end
    end
  end
endmodule

// File: rtl/rsum_row_filter.sv
module rsum_row_filter #(
  parameter int unsigned DIN_W   = 32,
  parameter int unsigned SUM_W   = 32,
  parameter int unsigned ROW_LEN = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [DIN_W-1:0] in_data,
  output logic             out_valid,
  output logic [SUM_W-1:0] out_sum
);
  localparam int unsigned COL_W = rsum_pkg::col_width(ROW_LEN);

  logic [COL_W-1:0] col_q;
  logic             row_last;
  logic             fill_done;
  logic [SUM_W-1:0] ext_data;
  logic [SUM_W-1:0] leaving;

  if (SUM_W > DIN_W) begin : g_widen
    assign ext_data = {{(SUM_W-DIN_W){in_data[DIN_W-1]}}, in_data};
  end else if (SUM_W == DIN_W) begin : g_same
    assign ext_data = in_data;
  end else begin : g_narrow
    assign ext_data = in_data[SUM_W-1:0];
  end

  rsum_col_tracker #(.ROW_LEN(ROW_LEN), .COL_W(COL_W)) u_col (
    .clk(clk), .rst(rst), .adv(in_valid),
    .col(col_q), .row_last(row_last), .fill_done(fill_done)
  );

  rsum_window #(.SUM_W(SUM_W), .TAPS(rsum_pkg::TAPS)) u_win (
    .clk(clk), .rst(rst), .shift(in_valid), .clear(row_last),
    .din(ext_data), .leaving(leaving)
  );

  rsum_accum #(.SUM_W(SUM_W)) u_acc (
    .clk(clk), .rst(rst), .step(in_valid), .clear(row_last),
    .fill_done(fill_done), .din(ext_data), .leaving(leaving),
    .out_valid(out_valid), .out_sum(out_sum)
  );
endmodule

// File: rtl/rsum_row_filter_chk.sv
module rsum_row_filter_chk #(
  parameter int unsigned SUM_W   = 32,
  parameter int unsigned ROW_LEN = 128,
  parameter int unsigned COL_W   = rsum_pkg::col_width(ROW_LEN)
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             out_valid,
  input logic [SUM_W-1:0] out_sum,
  input logic [COL_W-1:0] col
);
  localparam logic [31:0] FILL_IDX = 32'(rsum_pkg::TAPS - 1);
  localparam logic [31:0] LAST_IDX = 32'(ROW_LEN - 1);

  // R1
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_sum == '0 && col == '0));

  p_fill_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && 32'(col) < FILL_IDX) |=> !out_valid);

  p_valid_open_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && 32'(col) >= FILL_IDX) |=> out_valid);

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_sum)));

  p_idle_col_r5: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(col));

  p_row_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && 32'(col) == LAST_IDX) |=> (col == '0));
endmodule

bind rsum_row_filter rsum_row_filter_chk #(
  .SUM_W(SUM_W), .ROW_LEN(ROW_LEN), .COL_W(COL_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .out_valid(out_valid), .out_sum(out_sum), .col(col_q)
);

// File: tb/rsum_row_filter_bench.sv
`timescale 1ns/1ps
module rsum_row_filter_bench;
  localparam int unsigned DIN_W   = 32;
  localparam int unsigned SUM_W   = 32;
  localparam int unsigned ROW_LEN = 8;
  localparam int unsigned NVEC    = 25;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [DIN_W-1:0] in_data = '0;
  logic             out_valid;
  logic [SUM_W-1:0] out_sum;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  rsum_row_filter #(.DIN_W(DIN_W), .SUM_W(SUM_W), .ROW_LEN(ROW_LEN)) u_rsum_row_filter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_sum(out_sum)
  );

  // {in_valid, in_data, expected out_valid, expected out_sum} per cycle
  localparam logic [65:0] VEC [NVEC] = '{
    // row A: rising values 1..8 (R4 fill, R2 opening, R3 sums)
    {1'b1, 32'd1,  1'b0, 32'd1},
    {1'b1, 32'd2,  1'b0, 32'd3},
    {1'b1, 32'd3,  1'b0, 32'd6},
    {1'b1, 32'd4,  1'b0, 32'd10},
    {1'b1, 32'd5,  1'b1, 32'd15},
    {1'b1, 32'd6,  1'b1, 32'd20},
    {1'b1, 32'd7,  1'b1, 32'd25},
    {1'b1, 32'd8,  1'b1, 32'd30},
    // row B: negatives, a gap, restart after row end (R5, R6, R8)
    {1'b1, -32'sd1,   1'b0, -32'sd1},
    {1'b0, 32'd999,   1'b0, -32'sd1},
    {1'b1, -32'sd2,   1'b0, -32'sd3},
    {1'b1, -32'sd3,   1'b0, -32'sd6},
    {1'b1, -32'sd4,   1'b0, -32'sd10},
    {1'b1, 32'sd10,   1'b1, 32'sd0},
    {1'b1, 32'sd100,  1'b1, 32'sd101},
    {1'b1, -32'sd50,  1'b1, 32'sd53},
    {1'b1, 32'sd7,    1'b1, 32'sd63},
    // row C: constant one (R7)
    {1'b1, 32'd1, 1'b0, 32'd1},
    {1'b1, 32'd1, 1'b0, 32'd2},
    {1'b1, 32'd1, 1'b0, 32'd3},
    {1'b1, 32'd1, 1'b0, 32'd4},
    {1'b1, 32'd1, 1'b1, 32'd5},
    {1'b1, 32'd1, 1'b1, 32'd5},
    {1'b1, 32'd1, 1'b1, 32'd5},
    {1'b1, 32'd1, 1'b1, 32'd5}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one cycle of input, then sample just after the capturing edge
  task automatic step(input logic v, input logic [31:0] d, input logic r);
    @(negedge clk);
    in_valid = v;
    in_data  = d;
    rst      = r;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    // R1: reset state
    step(1'b0, 32'd0, 1'b1);
    step(1'b0, 32'd0, 1'b1);
    check("R1 valid", 32'(out_valid), 32'd0);
    check("R1 sum", out_sum, 32'd0);

    // table walk
    for (int i = 0; i < int'(NVEC); i++) begin
      step(VEC[i][65], VEC[i][64:33], 1'b0);
      check($sformatf("R2/R4 vec%0d valid", i), 32'(out_valid), 32'(VEC[i][32]));
      check($sformatf("R3/R5/R6 vec%0d sum", i), out_sum, VEC[i][31:0]);
    end

    // R9: reset mid-row discards window and column
    step(1'b1, 32'd9, 1'b0);
    step(1'b1, 32'd9, 1'b0);
    step(1'b1, 32'd9, 1'b0);
    step(1'b0, 32'd0, 1'b1);
    check("R9 reset valid", 32'(out_valid), 32'd0);
    for (int k = 1; k <= 5; k++) begin
      step(1'b1, 32'd2, 1'b0);
      check("R9 refill valid", 32'(out_valid), (k == 5) ? 32'd1 : 32'd0);
      check("R9 refill sum", out_sum, 32'(2 * k));
    end

    // R3: modular wrap with extreme values, fresh row after reset
    step(1'b0, 32'd0, 1'b1);
    for (int k = 0; k < 5; k++) step(1'b1, 32'h7FFF_FFFF, 1'b0);
    check("R3 wrap valid", 32'(out_valid), 32'd1);
    check("R3 wrap sum", out_sum, 32'h7FFF_FFFB);
    step(1'b1, 32'h8000_0000, 1'b0);
    check("R3 min sum", out_sum, 32'h7FFF_FFFC);

    // R5: idle cycle holds the sum and drops valid
    step(1'b0, 32'h1234, 1'b0);
    check("R5 idle valid", 32'(out_valid), 32'd0);
    check("R5 idle sum", out_sum, 32'h7FFF_FFFC);

    // R1: reset together with a valid sample wins
    step(1'b1, 32'd77, 1'b1);
    check("R1 collide valid", 32'(out_valid), 32'd0);
    check("R1 collide sum", out_sum, 32'd0);

    step(1'b0, 32'd0, 1'b0);
    finish_run();
  end
endmodule